// File: doc/BRIEF.md
# Serial Slave Pause Controller

This block is the pause logic of a serial-memory slave interface. It samples the chip select, the serial clock and an active-low pause input with a fast system clock. From these it decides when the serial interface is frozen and when it runs. While frozen, the shift path does not advance and the serial data output driver is switched off. Resuming continues from the same bit position. A pause can only start or end while the serial clock is low. If the pause input changes while the serial clock is high, the change takes effect at the next low phase.

The block carries a bit-position counter that is driven by the shift enable it produces. A neighbouring shift register and command decoder can use that counter as their bit index. Releasing chip select clears the interface state, including during a pause. After such a release, traffic restarts only when chip select is low again and the pause input is high.

Top module: `spi_hold_ctrl`

## Requirements
- R1: During and after reset, with chip select high, `hold_o`, `so_oe_o` and `shift_en_o` are 0 and `bit_cnt_o` is 0.
- R2: While chip select is high, `so_oe_o` stays 0 and `bit_cnt_o` stays 0, whatever the serial clock does.
- R3: With chip select low and the pause input high, `so_oe_o` is 1. Each rising edge of the serial clock adds one to `bit_cnt_o`, modulo 2^CNT_W (the default CNT_W is 3, so the count wraps from 7 to 0).
- R4: With chip select low, a low pause input seen together with a low serial clock enters the pause: `hold_o` becomes 1 and `so_oe_o` becomes 0.
- R5: If the pause input goes low while the serial clock is high, `hold_o` stays 0 until the serial clock goes low, and then becomes 1.
- R6: While `hold_o` is 1, `shift_en_o` is 0, and serial clock edges leave `bit_cnt_o` unchanged.
- R7: The pause ends only when the pause input is high while the serial clock is low. If the pause input rises while the serial clock is high, the pause lasts until the clock goes low. Counting then resumes from the count held before the pause.
- R8: Raising chip select during a pause clears the pause and the interface state: `hold_o` is 0, `so_oe_o` is 0 and `bit_cnt_o` is 0.
- R9: After chip select has been released, the interface stays idle (`so_oe_o` is 0, with no counting) while the pause input is low, even with chip select low. It becomes active only once the pause input is also high.
- R10: Each input change reaches the outputs within SYNC_STAGES+1 system clocks: SYNC_STAGES synchronizer flops plus one state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| csn_i | input | 1 | Active-low chip select (asynchronous) |
| holdn_i | input | 1 | Active-low pause request (asynchronous) |
| shift_en_o | output | 1 | One-cycle pulse per accepted serial clock rising edge |
| so_oe_o | output | 1 | Output enable for the serial data driver |
| hold_o | output | 1 | High while the interface is paused |
| bit_cnt_o | output | CNT_W | Bit position within the current unit |

## Verification
A wrong pause state shows up at the ports within one system clock. `so_oe_o` would overlap `hold_o`, or `shift_en_o` would pulse during a pause. In either case `bit_cnt_o` moves at the next serial clock edge and stays off from the expected count for the rest of the transfer. A pause that is entered or left while the serial clock is high is caught by comparing `hold_o` after each deferred edge. A missed clear on chip-select release shows up as a nonzero count after the next select. The bench settles each stimulus for more than SYNC_STAGES+1 system clocks and then compares the outputs with counts that it keeps itself.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_RUN  = 2'd1,
    HS_HOLD = 2'd2
  } hold_state_t;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_s,
  input  logic        csn_s,
  input  logic        holdn_s,
  output hold_state_t state_o,
  output logic        shift_en_o
);
  hold_state_t state_q, state_d;
  logic        sck_q;
  logic        sck_rise;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (!csn_s && holdn_s) state_d = HS_RUN;
      HS_RUN: begin
        if (csn_s)                   state_d = HS_IDLE;
        else if (!holdn_s && !sck_s) state_d = HS_HOLD;
      end
      HS_HOLD: begin
        if (csn_s)                  state_d = HS_IDLE;
        else if (holdn_s && !sck_s) state_d = HS_RUN;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_s;
    end
  end

  assign sck_rise   = sck_s & ~sck_q;
  assign shift_en_o = (state_q == HS_RUN) && sck_rise;
  assign state_o    = state_q;
endmodule

// File: rtl/spi_hold_bitcnt.sv
module spi_hold_bitcnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             holdn_i,
  output logic             shift_en_o,
  output logic             so_oe_o,
  output logic             hold_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  localparam int unsigned NSIG    = 3;
  localparam int unsigned IDX_SCK = 0;
  localparam int unsigned IDX_HLD = 1;
  localparam int unsigned IDX_CSN = 2;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b110;

  logic [1:0]      rst_sync_q;
  logic            rst_n_int;
  logic [NSIG-1:0] raw_vec, sync_vec;
  logic            sck_s, csn_s, holdn_s;
  hold_state_t     state;
  logic            shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign raw_vec[IDX_SCK] = sck_i;
  assign raw_vec[IDX_HLD] = holdn_i;
  assign raw_vec[IDX_CSN] = csn_i;

  spi_hold_sync #(
    .W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d_i(raw_vec), .q_o(sync_vec)
  );

  assign sck_s   = sync_vec[IDX_SCK];
  assign holdn_s = sync_vec[IDX_HLD];
  assign csn_s   = sync_vec[IDX_CSN];

  spi_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .sck_s(sck_s), .csn_s(csn_s),
    .holdn_s(holdn_s), .state_o(state), .shift_en_o(shift_en)
  );

  spi_hold_bitcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .clr_i(state == HS_IDLE),
    .inc_i(shift_en), .cnt_o(bit_cnt_o)
  );

  assign shift_en_o = shift_en;
  assign so_oe_o    = (state == HS_RUN);
  assign hold_o     = (state == HS_HOLD);
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck_s,
  input logic             shift_en_o,
  input logic             so_oe_o,
  input logic             hold_o,
  input logic [CNT_W-1:0] bit_cnt_o
);
  AST_HOLD_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> !so_oe_o); // R4
  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> !shift_en_o); // R6
  AST_HOLD_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> $stable(bit_cnt_o)); // R6
  AST_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> !$past(sck_s)); // R5
  AST_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(so_oe_o) && $past(hold_o)) |-> !$past(sck_s)); // R7
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!so_oe_o && !hold_o && $past(!so_oe_o && !hold_o)) |-> (bit_cnt_o == '0)); // R2
endmodule

bind spi_hold_ctrl spi_hold_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .shift_en_o(shift_en_o),
  .so_oe_o(so_oe_o), .hold_o(hold_o), .bit_cnt_o(bit_cnt_o)
);

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb;
  localparam int CNT_W  = 3;
  localparam int SETTLE = 6;
  localparam int MODV   = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n, sck, csn, holdn;
  logic shift_en, so_oe, hold;
  logic [CNT_W-1:0] bit_cnt;
  int checks = 0, errors = 0, exp_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_hold_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .holdn_i(holdn),
    .shift_en_o(shift_en), .so_oe_o(so_oe), .hold_o(hold), .bit_cnt_o(bit_cnt)
  );

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int n, bit counts);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; settle();
      sck = 1'b0; settle();
      if (counts) exp_cnt = (exp_cnt + 1) % MODV;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sck = 1'b0; csn = 1'b1; holdn = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 hold", hold, 0); check("R1 oe", so_oe, 0);
    check("R1 shift", shift_en, 0); check("R1 cnt", bit_cnt, 0);
    rst_n = 1'b1; settle();
    check("R1 cnt after", bit_cnt, 0); check("R1 oe after", so_oe, 0);
  endtask

  task automatic t_deselected();
    pulse(3, 1'b0);
    check("R2 oe", so_oe, 0); check("R2 cnt", bit_cnt, 0);
  endtask

  task automatic t_active();
    csn = 1'b0; settle(); exp_cnt = 0;
    check("R3 oe", so_oe, 1);
    pulse(3, 1'b1); check("R3 cnt", bit_cnt, exp_cnt);
    pulse(6, 1'b1); check("R3 wrap", bit_cnt, exp_cnt);
  endtask

  task automatic t_hold_low();
    holdn = 1'b0; settle();
    check("R4 hold", hold, 1); check("R4 oe", so_oe, 0);
    pulse(4, 1'b0); check("R6 cnt frozen", bit_cnt, exp_cnt);
    check("R6 still held", hold, 1);
    holdn = 1'b1; settle();
    check("R7 hold off", hold, 0); check("R7 oe back", so_oe, 1);
    pulse(2, 1'b1); check("R7 resume", bit_cnt, exp_cnt);
  endtask

  task automatic t_hold_deferred();
    sck = 1'b1; settle(); exp_cnt = (exp_cnt + 1) % MODV;
    holdn = 1'b0; settle();
    check("R5 deferred", hold, 0); check("R5 oe", so_oe, 1);
    sck = 1'b0; settle();
    check("R5 entered", hold, 1);
    sck = 1'b1; settle();
    holdn = 1'b1; settle();
    check("R7 deferred exit", hold, 1); check("R7 cnt", bit_cnt, exp_cnt);
    sck = 1'b0; settle();
    check("R7 exit", hold, 0);
    pulse(1, 1'b1); check("R7 count after", bit_cnt, exp_cnt);
  endtask

  task automatic t_deselect_in_hold();
    holdn = 1'b0; settle();
    check("R8 in hold", hold, 1);
    csn = 1'b1; settle(); exp_cnt = 0;
    check("R8 hold", hold, 0); check("R8 oe", so_oe, 0);
    check("R8 cnt", bit_cnt, 0);
    csn = 1'b0; settle();
    check("R9 idle oe", so_oe, 0); check("R9 idle hold", hold, 0);
    pulse(2, 1'b0); check("R9 no count", bit_cnt, 0);
    holdn = 1'b1; settle();
    check("R9 active", so_oe, 1); check("R9 cnt", bit_cnt, 0);
    pulse(1, 1'b1); check("R9 counts", bit_cnt, exp_cnt);
  endtask

  task automatic t_latency();
    holdn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 hold latency", hold, 1);
    holdn = 1'b1; settle();
  endtask

  initial begin
    t_reset();
    t_deselected();
    t_active();
    t_hold_low();
    t_hold_deferred();
    t_deselect_in_hold();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule